// File: doc/BRIEF.md
# Programmable countdown interrupt timer

This block is a register-mapped countdown timer of the kind found next to a processor's local interrupt controller. Software picks a divide ratio for the bus clock, chooses one-shot or periodic operation and an interrupt mask, then writes a start value. That value is copied into a read-only running count, which steps down by one on every divided clock tick. When the count expires, the block raises a one-cycle interrupt request unless the request is masked.

Software measures elapsed ticks by subtracting the running count from the start value. Writing a start value of zero stops the timer at once. The register port takes one write per cycle. Read data is combinational on the address.

The register map uses word addresses. Address 0 is the control register, which holds the vector in bits [7:0], the mask in bit 16 and the mode in bits [18:17]. Address 1 is the initial count, which can be read and written. Address 2 is the current count, which is read-only. Address 3 is the divide code in bits [3:0]. All bits not named here read as zero.

Top module: `cntdn_timer`

## Requirements
- R1: The divide code in bits [3:0] of address 3 selects the tick period in bus clocks. The codes map as 0x0→2, 0x1→4, 0x2→8, 0x3→16, 0x8→32, 0x9→64, 0xA→128 and 0xB→1. Every other code (0x4–0x7, 0xC–0xF) gives 2. The register reads back the 4-bit code that was written.
- R2: A write to address 1 stores the value as the initial count and copies it into the current count at the same clock edge. The same write restarts the prescaler using the selected divide value N. The first decrement therefore happens N clocks after the write edge.
- R3: While the initial count is zero, the current count stays at zero and irq never rises.
- R4: Writes to address 2 are ignored. The current count and the initial count are unchanged by them.
- R5: While running, the current count drops by exactly one every N bus clocks. After k*N clocks from a load of W it reads W−k, provided no expiry has occurred.
- R6: In one-shot mode (mode 00), the tick that takes the count from 1 to 0 raises irq for exactly one cycle. The count then stays at 0 with no further requests.
- R7: In periodic mode (mode 01), the tick after the count reaches 0 reloads it from the initial count. This gives one request every (W+1)*N clocks, and the first request comes W*N clocks after the load.
- R8: When the mask (bit 16 of address 0) is 1, irq stays low but counting continues unchanged.
- R9: Mode values 10 and 11 freeze the current count. The count resumes when one-shot or periodic mode is selected again. The mode field reads back at bits [18:17].
- R10: A new divide code takes effect only at the next tick of the divide ratio already in use, and writing it leaves the current count unchanged.
- R11: After reset, the control register reads 0x00010000 (one-shot, masked), the initial count, current count and divide code read zero, and irq is low.
- R12: With an initial count of 0xFFFFFFFF, the count runs down one per tick without expiring. Initial minus current equals the elapsed ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | ADDR_W | Word address of the register |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for reg_addr (combinational) |
| irq | output | 1 | One-cycle interrupt request on expiry |

## Verification
Errors in the prescaler phase or the latched divide ratio show up as a current count that is wrong by one. Each such error becomes visible within one divided period of the load or of the divide-code change. The bench reads the count at the exact cycle before and after a tick for each code, so an off-by-one period is caught at once. Errors in the count or reload state show up as a wrong reload value or as extra or missing irq pulses. These appear within one period of the timer and are checked against a computed count of expiries over random runs. A faulty frozen-mode or stop state lets the count drift, which a read a few tens of cycles later reveals.

// File: rtl/cntdn_pkg.sv
package cntdn_pkg;
   typedef enum logic [1:0] {
      MODE_ONESHOT  = 2'b00,
      MODE_PERIODIC = 2'b01,
      MODE_DEADLINE = 2'b10,
      MODE_RSVD     = 2'b11
   } tmode_e;

   localparam int REG_CTRL = 0;
   localparam int REG_INIT = 1;
   localparam int REG_CUR  = 2;
   localparam int REG_DIV  = 3;
   localparam int MASK_BIT = 16;
   localparam int MODE_LSB = 17;
   localparam int CODE_W   = 4;

   // Divide code to log2 of the ratio; codes with bit 2 set fall back to /2.
   function automatic logic [2:0] div_shift(input logic [CODE_W-1:0] code);
      if (code[2]) return 3'd1;
      return {code[3], code[1:0]} + 3'd1;
   endfunction
endpackage

// File: rtl/cntdn_regs.sv
module cntdn_regs
   import cntdn_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 2,
   parameter int VEC_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  wdata,
   input  logic [CNT_W-1:0]  cur,
   output logic [CNT_W-1:0]  rdata,
   output logic [CNT_W-1:0]  init_q,
   output tmode_e            mode_q,
   output logic              mask_q,
   output logic [CODE_W-1:0] code_q,
   output logic              ld
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
   localparam logic [ADDR_W-1:0] A_INIT = ADDR_W'(REG_INIT);
   localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'(REG_CUR);
   localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(REG_DIV);

   initial assert (CNT_W >= MODE_LSB + 2) else $error("CNT_W too small for control fields");
   initial assert (VEC_W <= MASK_BIT) else $error("VEC_W overlaps mask bit");
   initial assert (ADDR_W >= 2) else $error("ADDR_W must cover four registers");

   logic [VEC_W-1:0] vec_q;

   assign ld = wr && (addr == A_INIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         init_q <= '0;
         mode_q <= MODE_ONESHOT;
         mask_q <= 1'b1;
         vec_q  <= '0;
         code_q <= '0;
      end else if (wr) begin
         if (addr == A_INIT) init_q <= wdata;
         if (addr == A_CTRL) begin
            vec_q  <= wdata[VEC_W-1:0];
            mask_q <= wdata[MASK_BIT];
            mode_q <= tmode_e'(wdata[MODE_LSB+1:MODE_LSB]);
         end
         if (addr == A_DIV) code_q <= wdata[CODE_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_CTRL: begin
            rdata[VEC_W-1:0]            = vec_q;
            rdata[MASK_BIT]             = mask_q;
            rdata[MODE_LSB+1:MODE_LSB]  = mode_q;
         end
         A_INIT:  rdata = init_q;
         A_CUR:   rdata = cur;
         A_DIV:   rdata[CODE_W-1:0] = code_q;
         default: rdata = '0;
      endcase
   end

   // R4: a write aimed at the current count leaves the start value alone
   a_r4_cur_readonly: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == A_CUR) |=> $stable(init_q));
endmodule

// File: rtl/cntdn_prescaler.sv
module cntdn_prescaler
   import cntdn_pkg::*;
#(
   parameter int PRE_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic [CODE_W-1:0] code,
   output logic              tick
);
   initial assert (PRE_W >= 7) else $error("PRE_W must hold a divide of 128");

   logic [2:0]       shift_sel;
   logic [PRE_W-1:0] mask_new;
   logic [PRE_W-1:0] act_mask;
   logic [PRE_W-1:0] pre_cnt;

   assign shift_sel = div_shift(code);

   for (genvar i = 0; i < PRE_W; i++) begin : g_mask
      assign mask_new[i] = (int'(shift_sel) > i);
   end

   assign tick = (pre_cnt == act_mask);

   // The ratio is latched only at a boundary, so a code change never cuts a period short
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_cnt  <= '0;
         act_mask <= PRE_W'(1);
      end else if (restart || tick) begin
         pre_cnt  <= '0;
         act_mask <= mask_new;
      end else begin
         pre_cnt  <= pre_cnt + PRE_W'(1);
      end
   end

   // R10: the phase counter never runs past the period in force
   a_r10_phase_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      pre_cnt <= act_mask);
   // R2: a load restarts the divided period
   a_r2_restart_phase: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (pre_cnt == '0));
endmodule

// File: rtl/cntdn_core.sv
module cntdn_core
   import cntdn_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   input  logic [CNT_W-1:0] init_q,
   input  tmode_e           mode,
   input  logic             mask,
   output logic [CNT_W-1:0] cur_q,
   output logic             irq
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic running;
   assign running = (init_q != '0) && (mode == MODE_ONESHOT || mode == MODE_PERIODIC);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q <= '0;
         irq   <= 1'b0;
      end else if (ld) begin
         cur_q <= ld_val;
         irq   <= 1'b0;
      end else if (tick && running) begin
         if (cur_q != '0) begin
            cur_q <= cur_q - ONE;
            irq   <= (cur_q == ONE) && !mask;
         end else begin
            if (mode == MODE_PERIODIC) cur_q <= init_q;
            irq <= 1'b0;
         end
      end else begin
         irq <= 1'b0;
      end
   end

   // R2: a load is visible in the running count right after its edge
   a_r2_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (cur_q == $past(ld_val)));
   // R3: a zero start value keeps everything quiet
   a_r3_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && init_q == '0) |=> ((cur_q == $past(cur_q)) && !irq));
   // R5: single-step decrement on a tick
   a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ld && running && cur_q != '0) |=> (cur_q == $past(cur_q) - ONE));
   // R6: one-shot stays expired
   a_r6_oneshot_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && mode == MODE_ONESHOT && cur_q == '0) |=> (cur_q == '0));
   // R7: periodic reload from the start value
   a_r7_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ld && running && mode == MODE_PERIODIC && cur_q == '0) |=> (cur_q == $past(init_q)));
   // R8: a masked timer never requests
   a_r8_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !$past(mask));
   // R9: reserved modes freeze the count
   a_r9_frozen_modes: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && (mode == MODE_DEADLINE || mode == MODE_RSVD)) |=> $stable(cur_q));
endmodule

// File: rtl/cntdn_timer.sv
module cntdn_timer
   import cntdn_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 2,
   parameter int PRE_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [CNT_W-1:0]  reg_wdata,
   output logic [CNT_W-1:0]  reg_rdata,
   output logic              irq
);
   logic [CNT_W-1:0]  init_q;
   logic [CNT_W-1:0]  cur_q;
   tmode_e            mode_q;
   logic              mask_q;
   logic [CODE_W-1:0] code_q;
   logic              ld;
   logic              tick;

   cntdn_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .cur(cur_q), .rdata(reg_rdata), .init_q(init_q), .mode_q(mode_q),
      .mask_q(mask_q), .code_q(code_q), .ld(ld)
   );

   cntdn_prescaler #(.PRE_W(PRE_W)) pre_i (
      .clk(clk), .rst_n(rst_n), .restart(ld), .code(code_q), .tick(tick)
   );

   cntdn_core #(.CNT_W(CNT_W)) core_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .ld(ld), .ld_val(reg_wdata),
      .init_q(init_q), .mode(mode_q), .mask(mask_q), .cur_q(cur_q), .irq(irq)
   );
endmodule

// File: tb/cntdn_timer_tb_top.sv
module cntdn_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int n_cmp = 0;
   int n_bad = 0;
   int irq_cnt = 0;

   always #4 clk = ~clk;

   cntdn_timer dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   always @(posedge clk) if (rst_n && irq) irq_cnt <= irq_cnt + 1;

   task automatic chk(input string req, input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output longint v);
      reg_addr = a;
      #1;
      v = longint'(reg_rdata);
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int div_of(input int code);
      case (code)
         0: return 2;   1: return 4;   2: return 8;    3: return 16;
         8: return 32;  9: return 64;  10: return 128; 11: return 1;
         default: return 2;
      endcase
   endfunction

   function automatic longint m_cur(input longint w, input int n, input bit per, input int t);
      longint k = t / n;
      longint j;
      if (w == 0) return 0;
      if (k <= w) return w - k;
      if (!per) return 0;
      j = (k - w) % (w + 1);
      return (j == 0) ? 0 : w - (j - 1);
   endfunction

   function automatic longint m_irq(input longint w, input int n, input bit per, input bit msk, input int t);
      longint k;
      if (msk || w == 0 || t < 1) return 0;
      k = (t - 1) / n;
      if (k < w) return 0;
      return per ? 1 + (k - w) / (w + 1) : 1;
   endfunction

   task automatic run_case(input string req, input int code, input longint w,
                           input bit per, input bit msk, input int t);
      longint v;
      int base;
      wr(2'd1, 32'd0);
      wr(2'd3, 32'(code));
      wr(2'd0, (32'(per) << 17) | (32'(msk) << 16));
      wait_cyc(2);
      base = irq_cnt;
      wr(2'd1, w[31:0]);
      wait_cyc(t);
      rd(2'd2, v);
      chk(req, v, m_cur(w, div_of(code), per, t));
      chk(req, longint'(irq_cnt - base), m_irq(w, div_of(code), per, msk, t));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      longint v;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      chk("R11 irq", longint'(irq), 0);
      rd(2'd0, v); chk("R11 ctrl", v, 64'h0001_0000);
      rd(2'd1, v); chk("R11 init", v, 0);
      rd(2'd2, v); chk("R11 cur", v, 0);
      rd(2'd3, v); chk("R11 div", v, 0);

      // R1 / R5: every code, count read one cycle before and at a tick
      for (int c = 0; c < 16; c++) begin
         run_case("R1 R5 pre-tick", c, 1000, 1'b0, 1'b0, 5 * div_of(c) - 1);
         wait_cyc(1);
         rd(2'd2, v); chk("R1 R5 on-tick", v, 995);
         rd(2'd3, v); chk("R1 readback", v, c);
      end

      // R3: stopping
      wr(2'd1, 32'd0);
      wait_cyc(2);
      begin
         int base = irq_cnt;
         wait_cyc(300);
         rd(2'd2, v); chk("R3 cur stays 0", v, 0);
         chk("R3 no irq", longint'(irq_cnt - base), 0);
      end

      // R6 one-shot
      run_case("R6 at expiry", 11, 10, 1'b0, 1'b0, 10);
      run_case("R6 after expiry", 11, 10, 1'b0, 1'b0, 60);
      // R7 periodic
      run_case("R7 periodic", 0, 5, 1'b1, 1'b0, 54);
      run_case("R7 periodic /1", 11, 7, 1'b1, 1'b0, 100);
      // R8 mask
      run_case("R8 masked", 11, 3, 1'b1, 1'b1, 40);
      // R12 full range
      run_case("R12 all ones", 11, 64'hFFFF_FFFF, 1'b0, 1'b0, 2000);
      rd(2'd1, v);
      begin
         longint c;
         rd(2'd2, c);
         chk("R12 elapsed", v - c, 2000);
      end

      // R9 / R4: frozen modes and read-only current count
      wr(2'd1, 32'd0); wr(2'd3, 32'hB); wr(2'd0, 32'h0004_0000);
      wr(2'd1, 32'd100);
      wait_cyc(30);
      rd(2'd2, v); chk("R9 mode 10 frozen", v, 100);
      rd(2'd0, v); chk("R9 mode readback", v, 64'h0004_0000);
      wr(2'd2, 32'h55);
      wait_cyc(2);
      rd(2'd2, v); chk("R4 cur unchanged", v, 100);
      rd(2'd1, v); chk("R4 init unchanged", v, 100);
      wr(2'd0, 32'h0006_0000);
      wait_cyc(10);
      rd(2'd2, v); chk("R9 mode 11 frozen", v, 100);
      wr(2'd0, 32'h0);
      rd(2'd2, v); chk("R9 resume edge", v, 100);
      wait_cyc(5);
      rd(2'd2, v); chk("R9 resumed", v, 95);

      // R10: divide change at the next boundary
      wr(2'd1, 32'd0); wr(2'd3, 32'h1); wr(2'd0, 32'h0);
      wr(2'd1, 32'd1000);
      wait_cyc(6);
      wr(2'd3, 32'hB);
      rd(2'd2, v); chk("R10 count kept", v, 999);
      wait_cyc(1);
      rd(2'd2, v); chk("R10 old boundary", v, 998);
      wait_cyc(1);
      rd(2'd2, v); chk("R10 new ratio", v, 997);

      // Random runs (R5 R6 R7)
      void'($urandom(32'd1234));
      for (int i = 0; i < 20; i++) begin
         int c = int'($urandom_range(15, 0));
         int w = int'($urandom_range(300, 1));
         bit p = 1'($urandom_range(1, 0));
         int t = int'($urandom_range(400, 1));
         run_case("R5 R6 R7 random", c, w, p, 1'b0, t);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule